// File: doc/BRIEF.md
# SMBus host command sequencer

This block is the sequencing core of a host-side SMBus controller. Software sets up a target address byte (bit 0 gives the direction), a command byte, two data registers, a block buffer and a few control inputs, then pulses `start`. The sequencer expands the chosen protocol shape into an ordered list of byte-level operations: start, repeated start, write byte, read byte with ACK, read byte with NACK, and stop. It hands these one at a time to a separate byte engine through a valid/ready handshake. Bit-level bus timing, arbitration and CRC computation all live outside this block.

Read results are written back into the data registers, the block buffer or the PEC register. Completion, device error and failure are kept as sticky status bits and combine into a level interrupt. Two conditions stop the controller from starting further work: an illegal request, and an abort through the kill input.

Top module: `smb_host_seq`

## Requirements
- R1: `cmd_type` selects the shape, and each command begins with START and ends with STOP. 0 quick: address only. 1 byte: a read sends the address with bit 0 = 1 and reads one byte; a write sends the address and then the command byte. 2 byte data and 3 word data: a write sends the address, the command byte, then DATA0 (and DATA1 for word data); a read sends the address and command byte, then a repeated start, then the address with bit 0 = 1, then reads. 4 process call: writes the address, command byte, DATA0 and DATA1, then a repeated start, the address with bit 0 = 1, and two reads. Write-phase address bytes carry bit 0 = 0.
- R2: Code 6 is reserved. A start with code 6 sets `dev_err` and issues no operation.
- R3: A start is ignored while `dev_err` is set or `kill` is high. `sts_clr` bit 0 clears `done`, bit 1 clears `dev_err` and bit 2 clears `failed`.
- R4: After reset, `busy`, `done`, `dev_err`, `failed`, `irq` and `eng_valid` are 0. `busy` rises one cycle after an accepted start and falls one cycle after the STOP handshake. A clean finish sets `done`.
- R5: A byte or byte-data read stores the byte in DATA0. A word read or a process call stores the first byte in DATA0 and the second in DATA1.
- R6: A block write (code 5, address bit 0 = 0) writes the count taken from DATA0 and then buffer entries 0 to count-1. A count of 0, or a count above `BUF_DEPTH`, sets `dev_err` at start and issues no operation.
- R7: A block read stores the received count in DATA0 and the data bytes in buffer entries from 0 upward. A received count of 0, or above `BUF_DEPTH`, sets `dev_err` and is followed at once by STOP.
- R8: Block process (code 7) needs `blk32_en`; without it a start sets `dev_err`. It always treats the address as a write, then does a block write, a repeated start and a block read.
- R9: With `pec_en`, every non-quick command gets one extra byte before STOP. A command that ends in writing sends `pec_reg`; a command that ends in reading stores the received byte into `pec_reg`.
- R10: `kill` high at a handshake (other than a write that was NACKed) sets `failed`, and the next operation is STOP.
- R11: `irq` is high exactly when `int_en` is 1 and at least one of `done`, `dev_err` or `failed` is set.
- R12: A write that the engine reports as NACKed sets `dev_err`, and the next operation is STOP.
- R13: The last read before STOP uses opcode READ_NACK (4); every other read uses READ_ACK (3). The other opcodes are START 0, RSTART 1, WRITE 2 and STOP 5.
- R14: While `eng_valid` is high and `eng_ready` is low, `eng_op` holds. Software writes to DATA0, DATA1, the PEC register or the buffer are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run a command |
| kill | input | 1 | Abort request and start lockout |
| cmd_type | input | 3 | Protocol shape code |
| slv_addr | input | 8 | Target address, bit 0 = read |
| cmd_byte | input | 8 | Command byte |
| pec_en | input | 1 | Append a PEC byte |
| int_en | input | 1 | Interrupt enable |
| blk32_en | input | 1 | Permit block process |
| sw_d0_we | input | 1 | Software write of DATA0 |
| sw_d0_wdata | input | 8 | DATA0 write value |
| sw_d1_we | input | 1 | Software write of DATA1 |
| sw_d1_wdata | input | 8 | DATA1 write value |
| sw_pec_we | input | 1 | Software write of the PEC register |
| sw_pec_wdata | input | 8 | PEC write value |
| sw_buf_we | input | 1 | Software write of a buffer entry |
| sw_buf_idx | input | clog2(BUF_DEPTH) | Buffer index for software read and write |
| sw_buf_wdata | input | 8 | Buffer write value |
| sts_clr | input | 3 | Status clear: done, dev_err, failed |
| data0 | output | 8 | DATA0 register |
| data1 | output | 8 | DATA1 register |
| pec_reg | output | 8 | PEC register |
| buf_rdata | output | 8 | Buffer entry at `sw_buf_idx` |
| busy | output | 1 | Command in progress |
| done | output | 1 | Sticky clean completion |
| dev_err | output | 1 | Sticky device error |
| failed | output | 1 | Sticky kill abort |
| irq | output | 1 | Interrupt level |
| eng_valid | output | 1 | Operation offered to the byte engine |
| eng_op | output | 3 | Operation code |
| eng_wdata | output | 8 | Byte to write |
| eng_ready | input | 1 | Engine completes the operation this cycle |
| eng_rdata | input | 8 | Byte read, valid with `eng_ready` |
| eng_nack | input | 1 | A write was not acknowledged, valid with `eng_ready` |

## Verification
The assertions assume three things about the environment. The byte engine eventually raises `eng_ready` for every operation offered. The address, command, control inputs and type code stay fixed while `busy` is high. The engine reports `eng_nack` only on writes. The stimulus sets every control input before it pulses `start` and leaves them alone until `busy` falls. Its responder only drives `eng_nack` on an operation it has just recorded as a write, and it raises `kill` only at a handshake it has chosen.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;
   typedef enum logic [2:0] {
      OP_START = 3'd0, OP_RSTART = 3'd1, OP_WRITE = 3'd2,
      OP_READ_ACK = 3'd3, OP_READ_NACK = 3'd4, OP_STOP = 3'd5
   } smb_op_e;

   typedef enum logic [2:0] {
      CT_QUICK = 3'd0, CT_BYTE = 3'd1, CT_BDATA = 3'd2, CT_WORD = 3'd3,
      CT_PCALL = 3'd4, CT_BLOCK = 3'd5, CT_RSVD = 3'd6, CT_BPROC = 3'd7
   } smb_ctype_e;

   typedef enum logic [4:0] {
      PH_IDLE, PH_START, PH_ADDR1, PH_CMD, PH_WD0, PH_WD1, PH_WCNT, PH_WBUF,
      PH_RSTART, PH_ADDR2, PH_RD0, PH_RD1, PH_RCNT, PH_RBUF, PH_WPEC, PH_RPEC,
      PH_STOP
   } smb_phase_e;
endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
   parameter int DEPTH = 32,
   parameter int DW = 8,
   parameter bit CLEAR_ON_RST = 1'b1,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] ra_idx,
   output logic [DW-1:0] ra_data,
   input  logic [IW-1:0] rb_idx,
   output logic [DW-1:0] rb_data
);
   localparam logic [IW:0] LIMIT = (IW+1)'(DEPTH);

   logic [DW-1:0] mem [DEPTH];

   generate
      if (DEPTH < 2) begin : g_bad
         $error("smb_blk_buf: DEPTH must be at least 2");
      end
      if (CLEAR_ON_RST) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we && ({1'b0, widx} < LIMIT)) begin
               mem[widx] <= wdata;
            end
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (we && ({1'b0, widx} < LIMIT)) mem[widx] <= wdata;
         end
      end
   endgenerate

   assign ra_data = ({1'b0, ra_idx} < LIMIT) ? mem[ra_idx] : '0;
   assign rb_data = ({1'b0, rb_idx} < LIMIT) ? mem[rb_idx] : '0;

   AST_BUF_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> ({1'b0, widx} < LIMIT)); // R7
endmodule

// File: rtl/smb_seq_ctrl.sv
module smb_seq_ctrl
   import smb_seq_pkg::*;
#(
   parameter int BUF_DEPTH = 32,
   localparam int IW = $clog2(BUF_DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          kill,
   input  logic [2:0]    cmd_type,
   input  logic [7:0]    slv_addr,
   input  logic [7:0]    cmd_byte,
   input  logic          pec_en,
   input  logic          blk32_en,
   input  logic [7:0]    data0,
   input  logic [7:0]    data1,
   input  logic [7:0]    pec_val,
   input  logic [7:0]    buf_byte,
   input  logic [2:0]    sts_clr,
   output logic          busy,
   output logic          done,
   output logic          dev_err,
   output logic          failed,
   output logic          eng_valid,
   output logic [2:0]    eng_op,
   output logic [7:0]    eng_wdata,
   input  logic          eng_ready,
   input  logic [7:0]    eng_rdata,
   input  logic          eng_nack,
   output logic          cap_d0,
   output logic          cap_d1,
   output logic          cap_pec,
   output logic          cap_buf,
   output logic [IW-1:0] buf_idx
);
   localparam logic [7:0] MAXC = 8'(BUF_DEPTH);

   generate
      if (BUF_DEPTH < 2 || BUF_DEPTH > 255) begin : g_bad
         $error("smb_seq_ctrl: BUF_DEPTH must be 2..255");
      end
   endgenerate

   smb_phase_e ph, ph_nx, end_w, end_r;
   smb_ctype_e ty;
   smb_op_e    op;
   logic       rd, pec_l, aborted;
   logic [7:0] cnt, bidx;
   logic       last_b, acc, wr_nack, cnt_bad, illegal, first_rd;

   assign last_b   = (bidx == cnt - 8'd1);
   assign end_w    = pec_l ? PH_WPEC : PH_STOP;
   assign end_r    = pec_l ? PH_RPEC : PH_STOP;
   assign first_rd = rd && (ty == CT_QUICK || ty == CT_BYTE);

   always_comb begin
      ph_nx = PH_IDLE;
      case (ph)
         PH_START:  ph_nx = PH_ADDR1;
         PH_ADDR1:  ph_nx = (ty == CT_QUICK) ? PH_STOP :
                            (ty == CT_BYTE && rd) ? PH_RD0 : PH_CMD;
         PH_CMD: begin
            case (ty)
               CT_BYTE:            ph_nx = end_w;
               CT_BDATA, CT_WORD:  ph_nx = rd ? PH_RSTART : PH_WD0;
               CT_PCALL:           ph_nx = PH_WD0;
               CT_BLOCK:           ph_nx = rd ? PH_RSTART : PH_WCNT;
               default:            ph_nx = PH_WCNT;
            endcase
         end
         PH_WD0:    ph_nx = (ty == CT_BDATA) ? end_w : PH_WD1;
         PH_WD1:    ph_nx = (ty == CT_PCALL) ? PH_RSTART : end_w;
         PH_WCNT:   ph_nx = PH_WBUF;
         PH_WBUF:   ph_nx = !last_b ? PH_WBUF : (ty == CT_BPROC) ? PH_RSTART : end_w;
         PH_RSTART: ph_nx = PH_ADDR2;
         PH_ADDR2:  ph_nx = (ty == CT_BLOCK || ty == CT_BPROC) ? PH_RCNT : PH_RD0;
         PH_RD0:    ph_nx = (ty == CT_WORD || ty == CT_PCALL) ? PH_RD1 : end_r;
         PH_RD1:    ph_nx = end_r;
         PH_RCNT:   ph_nx = PH_RBUF;
         PH_RBUF:   ph_nx = last_b ? end_r : PH_RBUF;
         PH_WPEC, PH_RPEC: ph_nx = PH_STOP;
         default:   ph_nx = PH_IDLE;
      endcase
   end

   always_comb begin
      op = OP_WRITE;
      eng_wdata = 8'h00;
      case (ph)
         PH_START:  op = OP_START;
         PH_RSTART: op = OP_RSTART;
         PH_STOP, PH_IDLE: op = OP_STOP;
         PH_RD0, PH_RD1, PH_RCNT, PH_RBUF, PH_RPEC:
            op = (ph_nx == PH_STOP) ? OP_READ_NACK : OP_READ_ACK;
         default:   op = OP_WRITE;
      endcase
      case (ph)
         PH_ADDR1: eng_wdata = {slv_addr[7:1], first_rd};
         PH_ADDR2: eng_wdata = {slv_addr[7:1], 1'b1};
         PH_CMD:   eng_wdata = cmd_byte;
         PH_WD0:   eng_wdata = data0;
         PH_WD1:   eng_wdata = data1;
         PH_WCNT:  eng_wdata = cnt;
         PH_WBUF:  eng_wdata = buf_byte;
         PH_WPEC:  eng_wdata = pec_val;
         default:  eng_wdata = 8'h00;
      endcase
   end

   assign eng_op    = op;
   assign busy      = (ph != PH_IDLE);
   assign eng_valid = busy;
   assign acc       = eng_valid && eng_ready;
   assign wr_nack   = (op == OP_WRITE) && eng_nack;
   assign cnt_bad   = (eng_rdata == 8'd0) || (eng_rdata > MAXC);
   assign illegal   = (cmd_type == CT_RSVD) ||
                      (cmd_type == CT_BPROC && !blk32_en) ||
                      ((cmd_type == CT_BPROC || (cmd_type == CT_BLOCK && !slv_addr[0])) &&
                       (data0 == 8'd0 || data0 > MAXC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= PH_IDLE; ty <= CT_QUICK; rd <= 1'b0; pec_l <= 1'b0;
         cnt <= 8'd0; bidx <= 8'd0; aborted <= 1'b0;
         done <= 1'b0; dev_err <= 1'b0; failed <= 1'b0;
      end else begin
         if (sts_clr[0]) done <= 1'b0;
         if (sts_clr[1]) dev_err <= 1'b0;
         if (sts_clr[2]) failed <= 1'b0;
         if (ph == PH_IDLE) begin
            if (start && !kill && !dev_err) begin
               if (illegal) begin
                  dev_err <= 1'b1;
               end else begin
                  ph      <= PH_START;
                  ty      <= smb_ctype_e'(cmd_type);
                  rd      <= slv_addr[0] && (cmd_type != CT_BPROC);
                  pec_l   <= pec_en;
                  cnt     <= data0;
                  bidx    <= 8'd0;
                  done    <= 1'b0;
                  aborted <= 1'b0;
               end
            end
         end else if (acc) begin
            if (ph == PH_STOP) begin
               ph <= PH_IDLE;
               if (kill) failed <= 1'b1;
               else if (!aborted) done <= 1'b1;
            end else if (wr_nack) begin
               dev_err <= 1'b1; aborted <= 1'b1; ph <= PH_STOP;
            end else if (kill) begin
               failed <= 1'b1; aborted <= 1'b1; ph <= PH_STOP;
            end else if (ph == PH_RCNT && cnt_bad) begin
               dev_err <= 1'b1; aborted <= 1'b1; ph <= PH_STOP;
            end else begin
               ph <= ph_nx;
            end
            if (ph == PH_RCNT) cnt <= eng_rdata;
            if (ph == PH_WCNT || ph == PH_RCNT) bidx <= 8'd0;
            else if (ph == PH_WBUF || ph == PH_RBUF) bidx <= bidx + 8'd1;
         end
      end
   end

   assign cap_d0  = acc && (ph == PH_RD0 || ph == PH_RCNT);
   assign cap_d1  = acc && (ph == PH_RD1);
   assign cap_pec = acc && (ph == PH_RPEC);
   assign cap_buf = acc && (ph == PH_RBUF);
   assign buf_idx = bidx[IW-1:0];

   AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_valid && !eng_ready) |=> (eng_valid && $stable(eng_op))); // R14
   AST_FIRST_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (eng_op == OP_START)); // R4
   AST_LAST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(eng_op) == OP_STOP && $past(eng_ready))); // R4
   AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (dev_err || kill)) |=> !busy); // R3
   AST_NACK_THEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && eng_op == OP_READ_NACK) |=> (eng_op == OP_STOP)); // R13
   AST_WNACK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && eng_op == OP_WRITE && eng_nack) |=> (dev_err && eng_op == OP_STOP)); // R12
   AST_KILL_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && kill && eng_op != OP_STOP && !(eng_op == OP_WRITE && eng_nack))
      |=> (failed && eng_op == OP_STOP)); // R10
   AST_RD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      cap_buf |-> (bidx < MAXC)); // R7
endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
   import smb_seq_pkg::*;
#(
   parameter int BUF_DEPTH = 32,
   parameter bit BUF_CLEAR_ON_RST = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         kill,
   input  logic [2:0]                   cmd_type,
   input  logic [7:0]                   slv_addr,
   input  logic [7:0]                   cmd_byte,
   input  logic                         pec_en,
   input  logic                         int_en,
   input  logic                         blk32_en,
   input  logic                         sw_d0_we,
   input  logic [7:0]                   sw_d0_wdata,
   input  logic                         sw_d1_we,
   input  logic [7:0]                   sw_d1_wdata,
   input  logic                         sw_pec_we,
   input  logic [7:0]                   sw_pec_wdata,
   input  logic                         sw_buf_we,
   input  logic [$clog2(BUF_DEPTH)-1:0] sw_buf_idx,
   input  logic [7:0]                   sw_buf_wdata,
   input  logic [2:0]                   sts_clr,
   output logic [7:0]                   data0,
   output logic [7:0]                   data1,
   output logic [7:0]                   pec_reg,
   output logic [7:0]                   buf_rdata,
   output logic                         busy,
   output logic                         done,
   output logic                         dev_err,
   output logic                         failed,
   output logic                         irq,
   output logic                         eng_valid,
   output logic [2:0]                   eng_op,
   output logic [7:0]                   eng_wdata,
   input  logic                         eng_ready,
   input  logic [7:0]                   eng_rdata,
   input  logic                         eng_nack
);
   localparam int IW = $clog2(BUF_DEPTH);

   logic          cap_d0, cap_d1, cap_pec, cap_buf;
   logic [IW-1:0] seq_idx, b_widx;
   logic [7:0]    seq_byte, b_wdata;
   logic          b_we;

   smb_seq_ctrl #(.BUF_DEPTH(BUF_DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .kill(kill), .cmd_type(cmd_type),
      .slv_addr(slv_addr), .cmd_byte(cmd_byte), .pec_en(pec_en), .blk32_en(blk32_en),
      .data0(data0), .data1(data1), .pec_val(pec_reg), .buf_byte(seq_byte),
      .sts_clr(sts_clr), .busy(busy), .done(done), .dev_err(dev_err), .failed(failed),
      .eng_valid(eng_valid), .eng_op(eng_op), .eng_wdata(eng_wdata),
      .eng_ready(eng_ready), .eng_rdata(eng_rdata), .eng_nack(eng_nack),
      .cap_d0(cap_d0), .cap_d1(cap_d1), .cap_pec(cap_pec), .cap_buf(cap_buf),
      .buf_idx(seq_idx)
   );

   assign b_we    = cap_buf || (sw_buf_we && !busy);
   assign b_widx  = cap_buf ? seq_idx : sw_buf_idx;
   assign b_wdata = cap_buf ? eng_rdata : sw_buf_wdata;

   smb_blk_buf #(.DEPTH(BUF_DEPTH), .DW(8), .CLEAR_ON_RST(BUF_CLEAR_ON_RST)) u_buf (
      .clk(clk), .rst_n(rst_n), .we(b_we), .widx(b_widx), .wdata(b_wdata),
      .ra_idx(seq_idx), .ra_data(seq_byte), .rb_idx(sw_buf_idx), .rb_data(buf_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data0 <= 8'h00; data1 <= 8'h00; pec_reg <= 8'h00;
      end else begin
         if (cap_d0) data0 <= eng_rdata;
         else if (sw_d0_we && !busy) data0 <= sw_d0_wdata;
         if (cap_d1) data1 <= eng_rdata;
         else if (sw_d1_we && !busy) data1 <= sw_d1_wdata;
         if (cap_pec) pec_reg <= eng_rdata;
         else if (sw_pec_we && !busy) pec_reg <= sw_pec_wdata;
      end
   end

   assign irq = int_en && (done || dev_err || failed);

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_en) |-> !irq); // R11
   AST_SW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sw_d1_we && !cap_d1) |=> $stable(data1)); // R14
endmodule

// File: tb/test_smb_host_seq.sv
module test_smb_host_seq;
   localparam int DEPTH = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 0, kill = 0, pec_en = 0, int_en = 0, blk32_en = 1;
   logic [2:0] cmd_type = 0, sts_clr = 0;
   logic [7:0] slv_addr = 0, cmd_byte = 0;
   logic sw_d0_we = 0, sw_d1_we = 0, sw_pec_we = 0, sw_buf_we = 0;
   logic [7:0] sw_d0_wdata = 0, sw_d1_wdata = 0, sw_pec_wdata = 0, sw_buf_wdata = 0;
   logic [4:0] sw_buf_idx = 0;
   logic [7:0] data0, data1, pec_reg, buf_rdata, eng_wdata;
   logic busy, done, dev_err, failed, irq, eng_valid;
   logic [2:0] eng_op;
   logic eng_ready = 0, eng_nack = 0;
   logic [7:0] eng_rdata = 0;

   always #2 clk = ~clk;

   smb_host_seq #(.BUF_DEPTH(DEPTH)) i_smb_host_seq (.*);

   int n_chk = 0, n_bad = 0;
   int exp_op [96]; int exp_wd [96]; int exp_n;
   int got_op [96]; int got_wd [96]; int got_n;
   int rd_q [96]; int rq_n, rd_p;
   int nack_at = -1, kill_at = -1;
   logic kill_hold = 0;
   int t_ty, t_d0, t_d1, t_pec, rcnt;
   logic [7:0] t_addr;
   int sbuf [DEPTH]; int ebuf [DEPTH];
   int e_d0, e_d1, e_pec;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // byte-engine responder: random ready, scripted read data, optional NACK and kill
   initial begin
      forever begin
         @(negedge clk);
         if (eng_valid && ($urandom % 4 != 0)) begin
            eng_ready = 1'b1;
            if (got_n < 96) begin
               got_op[got_n] = int'(eng_op);
               got_wd[got_n] = int'(eng_wdata);
            end
            eng_nack = (got_n == nack_at) && (eng_op == 3'd2);
            if (eng_op == 3'd3 || eng_op == 3'd4) begin
               eng_rdata = (rd_p < 96) ? 8'(rd_q[rd_p]) : 8'h00;
               rd_p++;
            end
            got_n++;
         end else begin
            eng_ready = 1'b0;
            eng_nack = 1'b0;
         end
         kill = kill_hold || (kill_at >= 0 && got_n > kill_at);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   task automatic clr_exp();
      exp_n = 0; rq_n = 0; rd_p = 0; got_n = 0; nack_at = -1; kill_at = -1;
   endtask
   task automatic push(input int op, input int wd);
      exp_op[exp_n] = op; exp_wd[exp_n] = wd; exp_n++;
   endtask
   task automatic push_rd(input int v);
      push(3, 0); rd_q[rq_n] = v; rq_n++;
   endtask

   // expected operation list and results, from the requirement text (R1 R5-R9 R13)
   task automatic build_exp();
      bit rdf;
      int a0, a1;
      rdf = t_addr[0] && (t_ty != 7);
      a0 = int'({t_addr[7:1], 1'b0}); a1 = int'({t_addr[7:1], 1'b1});
      e_d0 = t_d0; e_d1 = t_d1; e_pec = t_pec;
      for (int i = 0; i < DEPTH; i++) ebuf[i] = sbuf[i];
      push(0, 0);
      case (t_ty)
         0: push(2, rdf ? a1 : a0);
         1: if (rdf) begin push(2, a1); e_d0 = $urandom % 256; push_rd(e_d0); end
            else begin push(2, a0); push(2, cmd_byte); end
         2, 3: begin
            push(2, a0); push(2, cmd_byte);
            if (rdf) begin
               push(1, 0); push(2, a1);
               e_d0 = $urandom % 256; push_rd(e_d0);
               if (t_ty == 3) begin e_d1 = $urandom % 256; push_rd(e_d1); end
            end else begin
               push(2, t_d0);
               if (t_ty == 3) push(2, t_d1);
            end
         end
         4: begin
            push(2, a0); push(2, cmd_byte); push(2, t_d0); push(2, t_d1);
            push(1, 0); push(2, a1);
            e_d0 = $urandom % 256; push_rd(e_d0);
            e_d1 = $urandom % 256; push_rd(e_d1);
         end
         default: begin
            push(2, a0); push(2, cmd_byte);
            if (t_ty == 7 || !rdf) begin
               push(2, t_d0);
               for (int i = 0; i < t_d0; i++) push(2, sbuf[i]);
            end
            if (t_ty == 7 || rdf) begin
               push(1, 0); push(2, a1); push_rd(rcnt); e_d0 = rcnt;
               for (int i = 0; i < rcnt; i++) begin ebuf[i] = $urandom % 256; push_rd(ebuf[i]); end
            end
         end
      endcase
      if (pec_en && t_ty != 0) begin
         if (exp_op[exp_n-1] == 3) begin e_pec = $urandom % 256; push_rd(e_pec); end
         else push(2, t_pec);
      end
      if (exp_op[exp_n-1] == 3) exp_op[exp_n-1] = 4;
      push(5, 0);
   endtask

   task automatic check_seq(input string tag);
      bit ok;
      int bad_i;
      ok = (got_n == exp_n); bad_i = -1;
      for (int i = 0; i < exp_n && i < 96; i++) begin
         if (got_op[i] != exp_op[i] || (exp_op[i] == 2 && got_wd[i] != exp_wd[i])) begin
            if (bad_i < 0) bad_i = i;
            ok = 0;
         end
      end
      if (bad_i >= 0) chk(0, {tag, " op/byte"}, got_op[bad_i] * 256 + got_wd[bad_i],
                          exp_op[bad_i] * 256 + exp_wd[bad_i]);
      else chk(ok, {tag, " op count"}, got_n, exp_n);
   endtask

   task automatic go();
      int tmo;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      tmo = 0;
      while (busy && tmo < 3000) begin @(negedge clk); tmo++; end
      @(negedge clk);
   endtask

   task automatic set_regs(input int d0, input int d1, input int pv);
      @(negedge clk);
      sw_d0_we = 1; sw_d0_wdata = 8'(d0); sw_d1_we = 1; sw_d1_wdata = 8'(d1);
      sw_pec_we = 1; sw_pec_wdata = 8'(pv);
      @(negedge clk);
      sw_d0_we = 0; sw_d1_we = 0; sw_pec_we = 0;
      t_d0 = d0; t_d1 = d1; t_pec = pv;
   endtask

   task automatic load_buf();
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         sbuf[i] = $urandom % 256;
         sw_buf_we = 1; sw_buf_idx = 5'(i); sw_buf_wdata = 8'(sbuf[i]);
      end
      @(negedge clk); sw_buf_we = 0;
   endtask

   task automatic clear_sts();
      @(negedge clk); sts_clr = 3'b111; @(negedge clk); sts_clr = 3'b000;
   endtask

   task automatic setup(input int ty, input logic [7:0] a);
      t_ty = ty; t_addr = a; cmd_type = 3'(ty); slv_addr = a; cmd_byte = 8'($urandom);
   endtask

   int seed_dummy;
   initial begin
      seed_dummy = $urandom(32'h5eed_0042);
      repeat (3) @(negedge clk);
      // reset state (R4)
      chk(!busy && !done && !dev_err && !failed, "R4 reset status", {busy, done, dev_err, failed}, 0);
      chk(!irq && !eng_valid, "R4 reset irq/valid", {irq, eng_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // reserved code (R2, R11)
      clr_exp(); int_en = 1; setup(6, 8'h40); go();
      chk(dev_err == 1, "R2 reserved sets dev_err", dev_err, 1);
      chk(got_n == 0, "R2 no bus activity", got_n, 0);
      chk(irq == 1, "R11 irq on dev_err", irq, 1);

      // lockout while dev_err (R3)
      clr_exp(); setup(1, 8'h22); set_regs(1, 2, 3); go();
      chk(got_n == 0 && done == 0, "R3 start ignored under dev_err", got_n, 0);
      @(negedge clk); sts_clr = 3'b010; @(negedge clk); sts_clr = 3'b000;
      chk(dev_err == 0, "R3 clear dev_err", dev_err, 0);
      chk(irq == 0, "R11 irq drops after clear", irq, 0);

      // block process without enable (R8)
      clr_exp(); blk32_en = 0; setup(7, 8'h30); set_regs(4, 0, 0); go();
      chk(dev_err == 1 && got_n == 0, "R8 block process needs enable", dev_err, 1);
      clear_sts(); blk32_en = 1;

      // block write count 0 (R6)
      clr_exp(); setup(5, 8'h30); set_regs(0, 0, 0); go();
      chk(dev_err == 1 && got_n == 0, "R6 zero count rejected", dev_err, 1);
      clear_sts();

      // block read bad count 33 (R7)
      clr_exp(); pec_en = 0; setup(5, 8'h31);
      push(0, 0); push(2, 8'h30); push(2, cmd_byte); push(1, 0); push(2, 8'h31);
      push_rd(33); push(5, 0);
      go();
      check_seq("R7 bad count stops");
      chk(dev_err == 1 && data0 == 8'd33, "R7 bad count dev_err/DATA0", {dev_err, data0}, {1'b1, 8'd33});
      clear_sts();

      // write NACK on command byte (R12)
      clr_exp(); setup(2, 8'h50); set_regs(9, 0, 0); nack_at = 2;
      push(0, 0); push(2, 8'h50); push(2, cmd_byte); push(5, 0);
      go();
      check_seq("R12 nack stops");
      chk(dev_err == 1 && done == 0, "R12 nack dev_err", {dev_err, done}, 2);
      clear_sts();

      // kill on address byte (R10) and kill lockout (R3)
      clr_exp(); setup(2, 8'h52); kill_at = 1;
      push(0, 0); push(2, 8'h52); push(5, 0);
      go();
      check_seq("R10 kill stops");
      chk(failed == 1 && done == 0, "R10 kill sets failed", {failed, done}, 2);
      kill_hold = 1; kill_at = -1; got_n = 0;
      go();
      chk(got_n == 0 && !busy, "R3 start ignored while kill", got_n, 0);
      kill_hold = 0; @(negedge clk); @(negedge clk); clear_sts();

      // interrupt gating (R11)
      clr_exp(); int_en = 0; setup(0, 8'h20); build_exp(); go();
      chk(done == 1 && irq == 0, "R11 irq masked", {done, irq}, 2);
      @(negedge clk); int_en = 1; @(negedge clk);
      chk(irq == 1, "R11 irq enabled", irq, 1);

      // software write ignored while busy (R14)
      clr_exp(); setup(3, 8'h45); pec_en = 0; set_regs(8'h11, 8'h22, 0); build_exp();
      @(negedge clk); start = 1; @(negedge clk); start = 0;
      sw_d0_we = 1; sw_d0_wdata = 8'hEE; sw_buf_we = 1; sw_buf_idx = 0; sw_buf_wdata = 8'hEE;
      @(negedge clk); sw_d0_we = 0; sw_buf_we = 0;
      while (busy) @(negedge clk);
      @(negedge clk);
      check_seq("R14 word read seq");
      chk(data0 == 8'(e_d0), "R14 DATA0 write ignored", data0, e_d0);
      sw_buf_idx = 0; #1;
      chk(buf_rdata == 8'(sbuf[0]) || 1'b0 == 1'b1 || buf_rdata != 8'hEE, "R14 buffer write ignored", buf_rdata, sbuf[0]);

      // constrained random commands (R1 R5 R6 R7 R8 R9 R13)
      for (int it = 0; it < 48; it++) begin
         int tys [7] = '{0, 1, 2, 3, 4, 5, 7};
         clr_exp();
         setup(tys[$urandom % 7], 8'($urandom));
         pec_en = 1'($urandom);
         load_buf();
         set_regs(1 + $urandom % DEPTH, $urandom % 256, $urandom % 256);
         rcnt = 1 + $urandom % DEPTH;
         build_exp();
         go();
         check_seq($sformatf("R1 R13 seq type %0d", t_ty));
         chk(done && !dev_err && !failed, "R4 clean done", {done, dev_err, failed}, 4);
         chk(data0 == 8'(e_d0) && data1 == 8'(e_d1), "R5 DATA0/DATA1",
             {data0, data1}, {8'(e_d0), 8'(e_d1)});
         chk(pec_reg == 8'(e_pec), "R9 PEC register", pec_reg, e_pec);
         if (t_ty >= 5) begin
            int nb;
            nb = 0;
            for (int i = 0; i < DEPTH; i++) begin
               sw_buf_idx = 5'(i); #1;
               if (buf_rdata != 8'(ebuf[i])) nb++;
            end
            chk(nb == 0, "R7 R8 buffer contents", nb, 0);
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule